// File: doc/BRIEF.md
# ATA PIO Timing Engine

This block carries out programmed-I/O transfers on a parallel ATA bus. The host side presents a request with a 4-bit register address, a direction bit and a 16-bit write word. The engine then runs one bus cycle in four phases: address setup, strobe, hold and end-of-cycle recovery. During that cycle it drives the chip selects, the device address, the read or write strobe and the data bus. It returns a one-cycle acknowledge together with the read word.

Each phase length is a programmable clock count taken from one of three timing sets: one for command-port accesses, and one fast data-port set for each of the two devices. Each set may also allow the device to stretch the strobe through IORDY. The engine remembers which device was last selected through the device/head register. It synchronises the device interrupt line and forwards it as a level. Two control inputs gate new transfers and drive the device reset line. For a 100 MHz clock, a mode-0 command set is 6/28/2/23 cycles, which gives a 600 ns cycle.

Top module: `ata_pio_engine`

## Requirements
- R1: Address bit 3 picks the chip select: 0 drives cs0_n low and 1 drives cs1_n low. `da` carries address bits 2:0. Both selects stay low-active only from the first setup cycle through the last hold cycle. Otherwise both are high and `da` is 0.
- R2: A timing set is packed as t1 in bits [TW-1:0], t2 in [2TW-1:TW], t4 in [3TW-1:2TW] and teoc in [4TW-1:3TW]. Setup lasts t1 cycles, strobe t2, hold t4 and recovery teoc. A count of 0 behaves as 1. Setup begins in the cycle after the request is sampled in idle.
- R3: During the strobe phase, dior_n is low for a read (wr=0) and diow_n is low for a write (wr=1). The two strobes are never low together.
- R4: On a write, dd_oe is high and dd_out equals the write word from the first setup cycle through the last hold cycle. At all other times dd_oe is low.
- R5: On a read, rdata takes the dd_in value present in the last strobe cycle and changes at no other time. Writes leave rdata unchanged.
- R6: ack is a single-cycle pulse in the first recovery cycle.
- R7: A request is accepted only in idle. After recovery there is one idle cycle, so with req held high the select is released for exactly teoc+1 cycles, counting the ack cycle.
- R8: Address 0 is the data port. If fast_en[d] is set, a data-port access uses device d's set (bit 0 is device 0, bit 1 is device 1). Every other access uses the command set. Device d is bit 4 of the last write to address 6, and it is 0 after reset.
- R9: Iordy passes through two flops. If the active set's IORDY enable is 1 and the synchronised value is low in the last strobe cycle, the strobe is extended until it reads high. If the enable is 0, IORDY is ignored.
- R10: irq equals intrq delayed by two clock edges.
- R11: While ctl_enable is low, requests start nothing. dev_rst_n is the registered inverse of ctl_dev_rst.
- R12: During reset, selects and strobes are high, and dd_oe, ack, irq, dev_rst_n and rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Transfer request, held until ack |
| wr | input | 1 | Direction, 1 = write |
| addr | input | 4 | Register address |
| wdata | input | DW | Write word |
| ack | output | 1 | Transfer done pulse |
| rdata | output | DW | Read word |
| ctl_enable | input | 1 | Allows new transfers |
| ctl_dev_rst | input | 1 | Requests device reset |
| fast_en | input | 2 | Per-device fast data-port timing enable |
| cmd_timing | input | 4*TW | Command-port timing set |
| cmd_iordy_en | input | 1 | IORDY enable for command set |
| dev0_timing | input | 4*TW | Device 0 data-port timing set |
| dev0_iordy_en | input | 1 | IORDY enable for device 0 set |
| dev1_timing | input | 4*TW | Device 1 data-port timing set |
| dev1_iordy_en | input | 1 | IORDY enable for device 1 set |
| dd_in | input | DW | Bus data from device |
| dd_out | output | DW | Bus data to device |
| dd_oe | output | 1 | Bus data output enable |
| da | output | 3 | Device register address |
| cs0_n | output | 1 | Chip select, command block |
| cs1_n | output | 1 | Chip select, control block |
| dior_n | output | 1 | Read strobe |
| diow_n | output | 1 | Write strobe |
| iordy | input | 1 | Device ready |
| intrq | input | 1 | Device interrupt |
| dev_rst_n | output | 1 | Device reset, active low |
| irq | output | 1 | Synchronised interrupt level |

## Verification
Two events can fall in the same cycle: the end of recovery and a fresh request that has already been waiting. The bench provokes this by keeping req high across two transfers, so the engine accepts the next access in the lone idle cycle. A second collision also occurs: IORDY is released while T2 has already expired, so the release meets the end of the strobe. The bench raises IORDY a set number of cycles into a stretched strobe. A behavioural model, built from phase lengths and a two-stage history of IORDY, judges every bus pin each cycle. Explicit counts of the select gap and the strobe length are compared against values worked out by hand.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RECOV  = 3'd4
  } ata_phase_e;

  localparam logic [3:0] DATA_PORT_ADDR = 4'h0;
  localparam logic [3:0] DEVSEL_ADDR    = 4'h6;
  localparam int         DEVSEL_BIT     = 4;

  localparam int NUM_SETS = 3;
  localparam int SET_CMD  = 0;
  localparam int SET_DEV0 = 1;
  localparam int SET_DEV1 = 2;

  localparam int NUM_FIELDS = 4;
  localparam int F_T1   = 0;
  localparam int F_T2   = 1;
  localparam int F_T4   = 2;
  localparam int F_TEOC = 3;

endpackage

// File: rtl/ata_sync2.sv
module ata_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/ata_pio_tsel.sv
module ata_pio_tsel
  import ata_pio_pkg::*;
#(
  parameter int TW = 8,
  localparam int SETW = NUM_FIELDS * TW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic            wr,
  input  logic [3:0]      addr,
  input  logic            dev_bit,
  input  logic [SETW-1:0] cmd_set,
  input  logic [SETW-1:0] dev0_set,
  input  logic [SETW-1:0] dev1_set,
  input  logic            cmd_ien,
  input  logic            dev0_ien,
  input  logic            dev1_ien,
  input  logic [1:0]      fast_en,
  output logic [SETW-1:0] set_out,
  output logic            ien_out
);
  logic            dev_q;
  logic [SETW-1:0] sets [0:NUM_SETS-1];
  logic            iens [0:NUM_SETS-1];
  logic [1:0]      idx;

  assign sets[SET_CMD]  = cmd_set;
  assign sets[SET_DEV0] = dev0_set;
  assign sets[SET_DEV1] = dev1_set;
  assign iens[SET_CMD]  = cmd_ien;
  assign iens[SET_DEV0] = dev0_ien;
  assign iens[SET_DEV1] = dev1_ien;

  always_comb begin
    idx = 2'(SET_CMD);
    if (addr == DATA_PORT_ADDR && fast_en[dev_q])
      idx = dev_q ? 2'(SET_DEV1) : 2'(SET_DEV0);
  end

  assign set_out = sets[idx];
  assign ien_out = iens[idx];

  always_ff @(posedge clk) begin
    if (rst)
      dev_q <= 1'b0;
    else if (accept && wr && addr == DEVSEL_ADDR)
      dev_q <= dev_bit;
  end
endmodule

// File: rtl/ata_pio_fsm.sv
module ata_pio_fsm
  import ata_pio_pkg::*;
#(
  parameter int TW = 8,
  parameter int DW = 16,
  localparam int SETW = NUM_FIELDS * TW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            enable,
  input  logic            wr,
  input  logic [3:0]      addr,
  input  logic [DW-1:0]   wdata,
  input  logic [SETW-1:0] set_in,
  input  logic            ien_in,
  input  logic            iordy_s,
  input  logic [DW-1:0]   dd_in,
  output logic            accept,
  output logic            ack,
  output logic [DW-1:0]   rdata,
  output logic            cs0_n,
  output logic            cs1_n,
  output logic [2:0]      da,
  output logic            dior_n,
  output logic            diow_n,
  output logic            dd_oe,
  output logic [DW-1:0]   dd_out
);
  ata_phase_e      ph;
  logic [TW-1:0]   cnt;
  logic [SETW-1:0] tim_q;
  logic            ien_q;
  logic [3:0]      addr_q;
  logic            wr_q;
  logic [DW-1:0]   wdata_q;
  logic [TW-1:0]   fld [0:NUM_FIELDS-1];
  logic            last;
  logic            active;
  logic            stall;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    assign fld[g] = tim_q[g*TW +: TW];
  end

  function automatic logic [TW-1:0] nz(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  assign accept = (ph == PH_IDLE) && req && enable;
  assign last   = (cnt <= TW'(1));
  assign stall  = ien_q && !iordy_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      tim_q   <= '0;
      ien_q   <= 1'b0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata   <= '0;
      ack     <= 1'b0;
    end else begin
      ack <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (accept) begin
            ph      <= PH_SETUP;
            tim_q   <= set_in;
            ien_q   <= ien_in;
            addr_q  <= addr;
            wr_q    <= wr;
            wdata_q <= wdata;
            cnt     <= nz(set_in[F_T1*TW +: TW]);
          end
        end
        PH_SETUP: begin
          if (last) begin
            ph  <= PH_STROBE;
            cnt <= nz(fld[F_T2]);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (last) begin
            if (!stall) begin
              ph  <= PH_HOLD;
              cnt <= nz(fld[F_T4]);
              if (!wr_q) rdata <= dd_in;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (last) begin
            ph  <= PH_RECOV;
            cnt <= nz(fld[F_TEOC]);
            ack <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_RECOV: begin
          if (last) ph <= PH_IDLE;
          else      cnt <= cnt - 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    active = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
    cs0_n  = !(active && !addr_q[3]);
    cs1_n  = !(active && addr_q[3]);
    da     = active ? addr_q[2:0] : 3'd0;
    dior_n = !(ph == PH_STROBE && !wr_q);
    diow_n = !(ph == PH_STROBE && wr_q);
    dd_oe  = active && wr_q;
    dd_out = wdata_q;
  end
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int TW = 8,
  parameter int DW = 16,
  localparam int SETW = NUM_FIELDS * TW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            wr,
  input  logic [3:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic            ack,
  output logic [DW-1:0]   rdata,
  input  logic            ctl_enable,
  input  logic            ctl_dev_rst,
  input  logic [1:0]      fast_en,
  input  logic [SETW-1:0] cmd_timing,
  input  logic            cmd_iordy_en,
  input  logic [SETW-1:0] dev0_timing,
  input  logic            dev0_iordy_en,
  input  logic [SETW-1:0] dev1_timing,
  input  logic            dev1_iordy_en,
  input  logic [DW-1:0]   dd_in,
  output logic [DW-1:0]   dd_out,
  output logic            dd_oe,
  output logic [2:0]      da,
  output logic            cs0_n,
  output logic            cs1_n,
  output logic            dior_n,
  output logic            diow_n,
  input  logic            iordy,
  input  logic            intrq,
  output logic            dev_rst_n,
  output logic            irq
);
  logic [1:0]      sync_q;
  logic            accept;
  logic [SETW-1:0] sel_set;
  logic            sel_ien;

  ata_sync2 #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({intrq, iordy}),
    .q   (sync_q)
  );

  assign irq = sync_q[1];

  ata_pio_tsel #(.TW(TW)) u_tsel (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .wr       (wr),
    .addr     (addr),
    .dev_bit  (wdata[DEVSEL_BIT]),
    .cmd_set  (cmd_timing),
    .dev0_set (dev0_timing),
    .dev1_set (dev1_timing),
    .cmd_ien  (cmd_iordy_en),
    .dev0_ien (dev0_iordy_en),
    .dev1_ien (dev1_iordy_en),
    .fast_en  (fast_en),
    .set_out  (sel_set),
    .ien_out  (sel_ien)
  );

  ata_pio_fsm #(.TW(TW), .DW(DW)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .enable  (ctl_enable),
    .wr      (wr),
    .addr    (addr),
    .wdata   (wdata),
    .set_in  (sel_set),
    .ien_in  (sel_ien),
    .iordy_s (sync_q[0]),
    .dd_in   (dd_in),
    .accept  (accept),
    .ack     (ack),
    .rdata   (rdata),
    .cs0_n   (cs0_n),
    .cs1_n   (cs1_n),
    .da      (da),
    .dior_n  (dior_n),
    .diow_n  (diow_n),
    .dd_oe   (dd_oe),
    .dd_out  (dd_out)
  );

  always_ff @(posedge clk) begin
    if (rst) dev_rst_n <= 1'b0;
    else     dev_rst_n <= !ctl_dev_rst;
  end
endmodule

// File: rtl/ata_pio_checker.sv
module ata_pio_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ack,
  input logic          cs0_n,
  input logic          cs1_n,
  input logic          dior_n,
  input logic          diow_n,
  input logic          dd_oe,
  input logic [DW-1:0] rdata
);
  a_r1_single_select: assert property (@(posedge clk) disable iff (rst)
    cs0_n || cs1_n);

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    dior_n || diow_n);

  a_r3_strobe_inside_select: assert property (@(posedge clk) disable iff (rst)
    (!dior_n || !diow_n) |-> (!cs0_n || !cs1_n));

  a_r4_drive_inside_select: assert property (@(posedge clk) disable iff (rst)
    dd_oe |-> (!cs0_n || !cs1_n));

  a_r6_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  a_r7_ack_released: assert property (@(posedge clk) disable iff (rst)
    ack |-> (cs0_n && cs1_n && dior_n && diow_n));

  a_r5_rdata_after_read: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata) |-> ($past(!dior_n) && dior_n && !(cs0_n && cs1_n)));
endmodule

bind ata_pio_engine ata_pio_checker #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ack    (ack),
  .cs0_n  (cs0_n),
  .cs1_n  (cs1_n),
  .dior_n (dior_n),
  .diow_n (diow_n),
  .dd_oe  (dd_oe),
  .rdata  (rdata)
);

// File: tb/ata_pio_engine_bench.sv
module ata_pio_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;
  localparam int DW = 16;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [DW-1:0] wdata = '0, dd_in = '0;
  logic ctl_enable = 1'b1, ctl_dev_rst = 1'b0;
  logic [1:0] fast_en = 2'b00;
  logic [7:0] c_t1 = 8'd6, c_t2 = 8'd28, c_t4 = 8'd2, c_te = 8'd23;
  logic [7:0] a_t1 = 8'd2, a_t2 = 8'd5, a_t4 = 8'd1, a_te = 8'd3;
  logic [7:0] b_t1 = 8'd1, b_t2 = 8'd3, b_t4 = 8'd0, b_te = 8'd2;
  logic c_ien = 1'b0, a_ien = 1'b0, b_ien = 1'b0;
  logic iordy = 1'b1, intrq = 1'b0;

  logic ack, dd_oe, cs0_n, cs1_n, dior_n, diow_n, dev_rst_n, irq;
  logic [DW-1:0] rdata, dd_out;
  logic [2:0] da;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_pio_engine #(.TW(TW), .DW(DW)) u_ata_pio_engine (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .ctl_enable(ctl_enable), .ctl_dev_rst(ctl_dev_rst),
    .fast_en(fast_en),
    .cmd_timing({c_te, c_t4, c_t2, c_t1}), .cmd_iordy_en(c_ien),
    .dev0_timing({a_te, a_t4, a_t2, a_t1}), .dev0_iordy_en(a_ien),
    .dev1_timing({b_te, b_t4, b_t2, b_t1}), .dev1_iordy_en(b_ien),
    .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe), .da(da),
    .cs0_n(cs0_n), .cs1_n(cs1_n), .dior_n(dior_n), .diow_n(diow_n),
    .iordy(iordy), .intrq(intrq), .dev_rst_n(dev_rst_n), .irq(irq)
  );

  int checks = 0, fails = 0, cyc = 0;
  int cs_len = 0, st_len = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // behavioural reference model
  int ph, rem, mt1, mt2, mt4, mte;
  logic [3:0] ma;
  logic mw, mien, mdev, mack, s1, s2, i1, i2, mrstn;
  logic [DW-1:0] md, mrd;

  function automatic int nz(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic pick(input logic [3:0] a);
    if (a == 4'h0 && fast_en[mdev]) begin
      if (mdev) begin mt1 = nz(b_t1); mt2 = nz(b_t2); mt4 = nz(b_t4); mte = nz(b_te); mien = b_ien; end
      else      begin mt1 = nz(a_t1); mt2 = nz(a_t2); mt4 = nz(a_t4); mte = nz(a_te); mien = a_ien; end
    end else begin
      mt1 = nz(c_t1); mt2 = nz(c_t2); mt4 = nz(c_t4); mte = nz(c_te); mien = c_ien;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; rem = 0; mack = 0; mrd = '0; mdev = 0; s1 = 0; s2 = 0;
      i1 = 0; i2 = 0; mrstn = 0; ma = '0; mw = 0; md = '0;
    end else begin
      mack = 0;
      case (ph)
        0: if (req && ctl_enable) begin
             ma = addr; mw = wr; md = wdata; pick(addr);
             if (wr && addr == 4'h6) mdev = wdata[4];
             ph = 1; rem = mt1;
           end
        1: if (rem <= 1) begin ph = 2; rem = mt2; end else rem--;
        2: if (rem <= 1) begin
             if (!(mien && !s2)) begin ph = 3; rem = mt4; if (!mw) mrd = dd_in; end
           end else rem--;
        3: if (rem <= 1) begin ph = 4; rem = mte; mack = 1; end else rem--;
        default: if (rem <= 1) ph = 0; else rem--;
      endcase
      s2 = s1; s1 = iordy; i2 = i1; i1 = intrq; mrstn = !ctl_dev_rst;
    end
    #(CLK_PERIOD/4);
    begin
      logic act_e;
      act_e = (ph >= 1 && ph <= 3);
      chk("R1 cs0_n", cs0_n, !(act_e && !ma[3]));
      chk("R1 cs1_n", cs1_n, !(act_e && ma[3]));
      chk("R1 da", da, act_e ? ma[2:0] : 3'd0);
      chk("R3 dior_n", dior_n, !(ph == 2 && !mw));
      chk("R3 diow_n", diow_n, !(ph == 2 && mw));
      chk("R4 dd_oe", dd_oe, act_e && mw);
      if (act_e && mw) chk("R4 dd_out", dd_out, md);
      chk("R6 ack", ack, mack);
      chk("R5 rdata", rdata, mrd);
      chk("R10 irq", irq, i2);
      chk("R11 dev_rst_n", dev_rst_n, mrstn);
    end
    if (!cs0_n || !cs1_n) cs_len++;
    if (!dior_n || !diow_n) st_len++;
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL R2 watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic xfer(input logic [3:0] a, input logic w, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd, output int cl, output int sl);
    int c0, s0;
    c0 = cs_len; s0 = st_len;
    @(negedge clk);
    req = 1'b1; addr = a; wr = w; wdata = d;
    do @(negedge clk); while (!ack);
    rd = rdata; req = 1'b0;
    cl = cs_len - c0; sl = st_len - s0;
  endtask

  initial begin
    logic [DW-1:0] rd;
    int cl, sl, gap, c0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 cs0_n", cs0_n, 1); chk("R12 cs1_n", cs1_n, 1);
    chk("R12 strobes", {dior_n, diow_n}, 2'b11);
    chk("R12 dd_oe", dd_oe, 0); chk("R12 ack", ack, 0);
    chk("R12 irq", irq, 0); chk("R12 dev_rst_n", dev_rst_n, 0);
    chk("R12 rdata", rdata, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2 R3 R4 command write, default mode-0 timing
    xfer(4'h7, 1'b1, 16'h00EC, rd, cl, sl);
    chk("R2 select length", cl, 6 + 28 + 2);
    chk("R2 strobe length", sl, 28);

    // R1 R5 control-block read
    dd_in = 16'hA5C3;
    xfer(4'hE, 1'b0, 16'h0, rd, cl, sl);
    chk("R5 read word", rd, 16'hA5C3);

    // R8 device 0 chosen, fast timing off then on
    xfer(4'h6, 1'b1, 16'h0000, rd, cl, sl);
    dd_in = 16'h1234;
    xfer(4'h0, 1'b0, 16'h0, rd, cl, sl);
    chk("R8 data port without fast", sl, 28);
    fast_en = 2'b01;
    dd_in = 16'h5678;
    xfer(4'h0, 1'b0, 16'h0, rd, cl, sl);
    chk("R8 device0 strobe", sl, 5);
    chk("R8 device0 select", cl, 2 + 5 + 1);
    chk("R5 fast read word", rd, 16'h5678);
    xfer(4'h1, 1'b0, 16'h0, rd, cl, sl);
    chk("R8 non-data port uses command set", sl, 28);

    // R8 device 1 chosen through address 6 bit 4
    xfer(4'h6, 1'b1, 16'h0010, rd, cl, sl);
    xfer(4'h0, 1'b1, 16'hBEEF, rd, cl, sl);
    chk("R8 device1 not fast", sl, 28);
    fast_en = 2'b11;
    xfer(4'h0, 1'b1, 16'hCAFE, rd, cl, sl);
    chk("R8 device1 strobe", sl, 3);
    chk("R2 zero hold acts as one", cl, 1 + 3 + 1);
    chk("R5 write leaves rdata", rd, 16'h5678);

    // R7 back-to-back: req held, end of recovery meets waiting request
    @(negedge clk);
    req = 1'b1; addr = 4'h0; wr = 1'b1; wdata = 16'h0F0F;
    do @(negedge clk); while (!ack);
    gap = 0;
    while (cs0_n && cs1_n) begin gap++; @(negedge clk); end
    chk("R7 idle gap", gap, 2 + 1);
    do @(negedge clk); while (!ack);
    req = 1'b0;

    // R9 IORDY ignored when disabled
    fast_en = 2'b00;
    iordy = 1'b0;
    xfer(4'h7, 1'b0, 16'h0, rd, cl, sl);
    chk("R9 iordy ignored", sl, 28);

    // R9 IORDY stretches strobe; release meets T2 expiry
    c_ien = 1'b1;
    fork
      xfer(4'h7, 1'b0, 16'h0, rd, cl, sl);
      begin
        do @(negedge clk); while (dior_n);
        repeat (40) @(negedge clk);
        iordy = 1'b1;
      end
    join
    chk("R9 stretched strobe", sl, 43);
    c_ien = 1'b0;

    // R11 enable low blocks requests
    ctl_enable = 1'b0;
    c0 = cs_len;
    @(negedge clk); req = 1'b1; addr = 4'h7; wr = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11 disabled start", cs_len - c0, 0);
    req = 1'b0; ctl_enable = 1'b1;
    ctl_dev_rst = 1'b1;
    @(negedge clk);
    chk("R11 device reset", dev_rst_n, 0);
    ctl_dev_rst = 1'b0;
    @(negedge clk);
    chk("R11 device reset release", dev_rst_n, 1);

    // R10 interrupt forwarding
    intrq = 1'b1;
    @(negedge clk);
    chk("R10 irq after one edge", irq, 0);
    @(negedge clk);
    chk("R10 irq after two edges", irq, 1);
    intrq = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 irq cleared", irq, 0);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule